// File: doc/BRIEF.md
# Oversampled Serial Receiver with Two-Character Error-Tagged Buffer

The block turns an asynchronous serial line into characters. A baud tick enable paces the receiver. Every bit cell lasts 16 ticks, or 8 ticks when double speed is selected. The receiver first passes the line through a two-flop synchronizer. It then decides each bit by a three-sample majority vote taken around the middle of the cell. Completed characters go into a two-entry buffer. Each entry keeps its own frame-error, parity-error and overrun flags, so the status always describes the character at the head, the one that the next read returns.

A third character may complete while the buffer is full. It then waits in a holding register and moves into the buffer in the same cycle that a read frees an entry. If a new start bit arrives while the buffer is full and a character is already waiting, the receiver marks an overrun. In multi-processor mode each frame carries an extra mark bit. Frames whose mark bit is zero are discarded, so a node listens only for address frames until software clears the mode.

The frame controller is a state machine with six states: `ST_IDLE`, `ST_START`, `ST_DATA`, `ST_MARK`, `ST_PARITY` and `ST_STOP`. Its transitions are:
- idle to start on a low line at a tick;
- start back to idle on a false start (majority high);
- start to data on a valid start bit;
- data to mark (multi-processor mode), to parity (parity enabled) or to stop, after the last data bit;
- mark to parity or to stop;
- parity to stop;
- stop to idle, which delivers the character;
- any state to idle while the receiver is disabled.

Top module: `uart_rx_buf`

## Requirements
- R1: After reset `stat_rx_avail`, `stat_frm_err`, `stat_par_err` and `stat_ovr` are 0. The three error flags read 0 whenever the buffer is empty.
- R2: A frame is a low start bit, 8 data bits sent least significant bit first, an optional mark bit (multi-processor mode only), an optional even-parity bit (parity enabled only) and one stop bit. The idle line is high. A complete frame puts its data on `rd_data` with `stat_rx_avail` high.
- R3: Each bit is the majority of three samples, taken at tick offsets mid-1, mid and mid+1 of its cell, where mid is half the cell length. A single-tick glitch at mid therefore does not change the bit. A start bit whose vote comes out high is dropped, and no character results from it.
- R4: `stat_frm_err` is 1 for a head character whose stop bit voted 0, and 0 when it voted 1.
- R5: `stat_par_err` is 1 only if parity was enabled when the frame's start bit was detected and the XOR of the data bits, the mark bit (if present) and the parity bit is 1.
- R6: The buffer holds two characters in arrival order. A pulse on `rd_pop` drops the head entry together with its flags. `stat_rx_avail` is 1 while at least one character is unread.
- R7: A character that completes while the buffer is full waits in a holding register. It enters the buffer in the same cycle as the read that frees an entry, and keeps arrival order.
- R8: An overrun is marked when a start bit is detected while the buffer is full and a character is waiting. The waiting character, or the newer character that replaces it on completion, carries `stat_ovr` = 1 when it reaches the head. A character reaches the buffer with the overrun flag at 0 in any other case.
- R9: With `cfg_mp_mode` = 1, a frame whose mark bit is 0 is discarded, and a frame whose mark bit is 1 is stored (data only).
- R10: With `cfg_dbl_spd` = 1 a bit cell lasts 8 ticks instead of 16, and reception otherwise works the same way.
- R11: While `cfg_rx_en` is 0, no start bit is detected and no character is produced. Lowering `cfg_rx_en` abandons a frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial line, idle high |
| baud_tick | input | 1 | Oversampling tick enable |
| cfg_rx_en | input | 1 | Receiver enable |
| cfg_par_en | input | 1 | Even parity bit present and checked |
| cfg_dbl_spd | input | 1 | 8 ticks per bit instead of 16 |
| cfg_mp_mode | input | 1 | Multi-processor address filtering |
| rd_pop | input | 1 | Read strobe, drops the head character |
| rd_data | output | 8 | Head character data |
| stat_rx_avail | output | 1 | At least one unread character |
| stat_frm_err | output | 1 | Head character had a stop-bit error |
| stat_ovr | output | 1 | Characters were lost before the head character |
| stat_par_err | output | 1 | Head character had a parity error |

## Verification
The overrun case is the hardest one to reach from the ports. It needs a full buffer, a character parked in the holding register, and a fresh start bit, all with no read in between. The stimulus sends four frames back to back with reads held off. It then reads out the buffer and expects the fourth character to replace the third and carry the overrun flag. A separate run with three frames and late reads shows the held character moving in without the flag. Frames with a one-tick glitch at mid-cell and a short false start exercise the majority vote.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_MARK,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic fe;
        logic pe;
        logic ovr;
    } rx_flags_t;

endpackage

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned OS_NORM = 16,
    parameter int unsigned OS_FAST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              tick,
    input  logic              rx_en,
    input  logic              par_en,
    input  logic              dbl,
    input  logic              mp,
    output logic              start_det,
    output logic              done,
    output logic [DATA_W-1:0] done_data,
    output logic              done_fe,
    output logic              done_pe
);
    localparam int unsigned CNT_W = $clog2(OS_NORM);
    localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    rx_state_e         state_q, state_d;
    logic              rx_m, rx_s;
    logic [CNT_W-1:0]  os_cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] data_q;
    logic              mark_q, par_q;
    logic [2:0]        smp_q;
    logic              l_par, l_dbl, l_mp;
    logic [CNT_W-1:0]  os_last, os_mid;
    logic              in_win, cell_end, vote, last_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) {rx_s, rx_m} <= 2'b11;
        else        {rx_s, rx_m} <= {rx_m, rx_line};
    end

    assign os_last   = l_dbl ? CNT_W'(OS_FAST - 1) : CNT_W'(OS_NORM - 1);
    assign os_mid    = l_dbl ? CNT_W'(OS_FAST / 2) : CNT_W'(OS_NORM / 2);
    assign in_win    = (os_cnt_q == os_mid - CNT_W'(1)) || (os_cnt_q == os_mid)
                    || (os_cnt_q == os_mid + CNT_W'(1));
    assign cell_end  = tick && (state_q != ST_IDLE) && (os_cnt_q == os_last);
    assign vote      = (smp_q[0] & smp_q[1]) | (smp_q[1] & smp_q[2]) | (smp_q[0] & smp_q[2]);
    assign last_data = (idx_q == IDX_W'(DATA_W - 1));
    assign start_det = (state_q == ST_IDLE) && (state_d == ST_START);

    // next-state process
    always_comb begin
        state_d = state_q;
        if (!rx_en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (tick && !rx_s) state_d = ST_START;
                ST_START:  if (cell_end) state_d = vote ? ST_IDLE : ST_DATA;
                ST_DATA:   if (cell_end && last_data)
                               state_d = l_mp ? ST_MARK : (l_par ? ST_PARITY : ST_STOP);
                ST_MARK:   if (cell_end) state_d = l_par ? ST_PARITY : ST_STOP;
                ST_PARITY: if (cell_end) state_d = ST_STOP;
                ST_STOP:   if (cell_end) state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_cnt_q  <= '0;
            idx_q     <= '0;
            data_q    <= '0;
            mark_q    <= 1'b0;
            par_q     <= 1'b0;
            smp_q     <= 3'b111;
            l_par     <= 1'b0;
            l_dbl     <= 1'b0;
            l_mp      <= 1'b0;
            done      <= 1'b0;
            done_data <= '0;
            done_fe   <= 1'b0;
            done_pe   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start_det) begin
                os_cnt_q <= '0;
                idx_q    <= '0;
                par_q    <= 1'b0;
                l_par    <= par_en;
                l_dbl    <= dbl;
                l_mp     <= mp;
            end else if (tick && rx_en && (state_q != ST_IDLE)) begin
                os_cnt_q <= (os_cnt_q == os_last) ? '0 : os_cnt_q + CNT_W'(1);
                if (in_win) smp_q <= {smp_q[1:0], rx_s};
                if (cell_end) begin
                    unique case (state_q)
                        ST_DATA: begin
                            data_q <= {vote, data_q[DATA_W-1:1]};
                            idx_q  <= idx_q + IDX_W'(1);
                            par_q  <= par_q ^ vote;
                        end
                        ST_MARK: begin
                            mark_q <= vote;
                            par_q  <= par_q ^ vote;
                        end
                        ST_PARITY: par_q <= par_q ^ vote;
                        ST_STOP: begin
                            done      <= !(l_mp && !mark_q);
                            done_data <= data_q;
                            done_fe   <= !vote;
                            done_pe   <= l_par && par_q;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // R11
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state_q == ST_IDLE));

    // R2
    done_at_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state_q == ST_IDLE));

    // R3
    sample_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && state_d == ST_DATA) |-> (os_cnt_q == os_last));

endmodule

// File: rtl/rx_buf2.sv
module rx_buf2
    import uart_rx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              new_v,
    input  logic [DATA_W-1:0] new_data,
    input  rx_flags_t         new_flg,
    input  logic              start_det,
    input  logic              pop,
    output logic              avail,
    output logic [DATA_W-1:0] head_data,
    output rx_flags_t         head_flg
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem_data [DEPTH];
    rx_flags_t         mem_flg  [DEPTH];
    logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q;
    logic [CNT_W-1:0]  count_q;
    logic              pend_v_q, pend_v_d;
    logic [DATA_W-1:0] pend_data_q, pend_data_d;
    rx_flags_t         pend_flg_q, pend_flg_d;
    logic              pop_ok, space, push_v;
    logic [DATA_W-1:0] push_data;
    rx_flags_t         push_flg;

    assign pop_ok = pop && (count_q != '0);
    assign space  = (count_q != CNT_W'(DEPTH)) || pop_ok;

    always_comb begin
        push_v      = 1'b0;
        push_data   = pend_data_q;
        push_flg    = pend_flg_q;
        pend_v_d    = pend_v_q;
        pend_data_d = pend_data_q;
        pend_flg_d  = pend_flg_q;
        if (pend_v_q) begin
            if (space) begin
                push_v      = 1'b1;
                pend_v_d    = new_v;
                pend_data_d = new_data;
                pend_flg_d  = new_flg;
            end else if (new_v) begin
                pend_data_d    = new_data;
                pend_flg_d     = new_flg;
                pend_flg_d.ovr = 1'b1;
            end else if (start_det) begin
                pend_flg_d.ovr = 1'b1;
            end
        end else if (new_v) begin
            if (space) begin
                push_v    = 1'b1;
                push_data = new_data;
                push_flg  = new_flg;
            end else begin
                pend_v_d    = 1'b1;
                pend_data_d = new_data;
                pend_flg_d  = new_flg;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr_q    <= '0;
            wr_ptr_q    <= '0;
            count_q     <= '0;
            pend_v_q    <= 1'b0;
            pend_data_q <= '0;
            pend_flg_q  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_data[i] <= '0;
                mem_flg[i]  <= '0;
            end
        end else begin
            pend_v_q    <= pend_v_d;
            pend_data_q <= pend_data_d;
            pend_flg_q  <= pend_flg_d;
            if (push_v) begin
                mem_data[wr_ptr_q] <= push_data;
                mem_flg[wr_ptr_q]  <= push_flg;
                wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + PTR_W'(1);
            end
            if (pop_ok)
                rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + PTR_W'(1);
            count_q <= count_q + CNT_W'(push_v) - CNT_W'(pop_ok);
        end
    end

    assign avail     = (count_q != '0);
    assign head_data = mem_data[rd_ptr_q];
    assign head_flg  = mem_flg[rd_ptr_q];

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    // R7
    pend_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_v_q |-> (count_q == CNT_W'(DEPTH)));

    // R7
    pend_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && pend_v_q) |=> (count_q == CNT_W'(DEPTH)));

endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
    import uart_rx_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned DEPTH   = 2,
    parameter int unsigned OS_NORM = 16,
    parameter int unsigned OS_FAST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              baud_tick,
    input  logic              cfg_rx_en,
    input  logic              cfg_par_en,
    input  logic              cfg_dbl_spd,
    input  logic              cfg_mp_mode,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              stat_rx_avail,
    output logic              stat_frm_err,
    output logic              stat_ovr,
    output logic              stat_par_err
);
    logic              start_det, done, done_fe, done_pe, avail;
    logic [DATA_W-1:0] done_data, head_data;
    rx_flags_t         new_flg, head_flg;

    rx_frame_fsm #(.DATA_W(DATA_W), .OS_NORM(OS_NORM), .OS_FAST(OS_FAST)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_line   (rx_line),
        .tick      (baud_tick),
        .rx_en     (cfg_rx_en),
        .par_en    (cfg_par_en),
        .dbl       (cfg_dbl_spd),
        .mp        (cfg_mp_mode),
        .start_det (start_det),
        .done      (done),
        .done_data (done_data),
        .done_fe   (done_fe),
        .done_pe   (done_pe)
    );

    always_comb begin
        new_flg     = '0;
        new_flg.fe  = done_fe;
        new_flg.pe  = done_pe;
    end

    rx_buf2 #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .new_v     (done),
        .new_data  (done_data),
        .new_flg   (new_flg),
        .start_det (start_det),
        .pop       (rd_pop),
        .avail     (avail),
        .head_data (head_data),
        .head_flg  (head_flg)
    );

    assign rd_data       = head_data;
    assign stat_rx_avail = avail;
    assign stat_frm_err  = avail & head_flg.fe;
    assign stat_par_err  = avail & head_flg.pe;
    assign stat_ovr      = avail & head_flg.ovr;

    // R6
    pop_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && !done && !start_det && !avail) |=> !stat_rx_avail);

endmodule

// File: tb/uart_rx_buf_tb_top.sv
module uart_rx_buf_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       baud_tick = 1'b0;
    logic       cfg_rx_en = 1'b1;
    logic       cfg_par_en = 1'b0;
    logic       cfg_dbl_spd = 1'b0;
    logic       cfg_mp_mode = 1'b0;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic       stat_rx_avail, stat_frm_err, stat_ovr, stat_par_err;
    int         n_cmp = 0;
    int         n_err = 0;
    logic [1:0] tick_div = 2'd0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        tick_div  <= tick_div + 2'd1;
        baud_tick <= (tick_div == 2'd3);
    end

    uart_rx_buf dut_i (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_tick(baud_tick),
        .cfg_rx_en(cfg_rx_en), .cfg_par_en(cfg_par_en), .cfg_dbl_spd(cfg_dbl_spd),
        .cfg_mp_mode(cfg_mp_mode), .rd_pop(rd_pop), .rd_data(rd_data),
        .stat_rx_avail(stat_rx_avail), .stat_frm_err(stat_frm_err),
        .stat_ovr(stat_ovr), .stat_par_err(stat_par_err)
    );

    // {data9[8:0], par, mp, dbl, stop, badpar, exp_accept, exp_fe, exp_pe}
    localparam logic [16:0] VEC [0:8] = '{
        {9'h0A5, 5'b00010, 3'b100},
        {9'h03C, 5'b10010, 3'b100},
        {9'h0C3, 5'b10011, 3'b101},
        {9'h05A, 5'b00000, 3'b110},
        {9'h1F0, 5'b01010, 3'b100},
        {9'h00F, 5'b01010, 3'b000},
        {9'h081, 5'b00110, 3'b100},
        {9'h1E7, 5'b11101, 3'b111},
        {9'h000, 5'b10110, 3'b100}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!baud_tick) @(posedge clk);
            #1;
        end
    endtask

    task automatic hold_bit(input logic v, input int os, input bit glitch);
        rx_line = v;
        if (glitch) begin
            wait_ticks(os / 2);
            rx_line = ~v;
            wait_ticks(1);
            rx_line = v;
            wait_ticks(os - os / 2 - 1);
        end else begin
            wait_ticks(os);
        end
    endtask

    task automatic send_frame(input logic [8:0] d9, input bit par, input bit mp,
                              input bit dbl, input bit stopv, input bit badp,
                              input int glitch_at);
        int   os;
        int   pos;
        logic p;
        cfg_par_en  = par;
        cfg_mp_mode = mp;
        cfg_dbl_spd = dbl;
        os  = dbl ? 8 : 16;
        p   = mp ? ^d9 : ^d9[7:0];
        p   = p ^ badp;
        pos = 0;
        hold_bit(1'b0, os, glitch_at == pos);
        pos++;
        for (int b = 0; b < 8; b++) begin
            hold_bit(d9[b], os, glitch_at == pos);
            pos++;
        end
        if (mp) hold_bit(d9[8], os, 1'b0);
        if (par) hold_bit(p, os, 1'b0);
        hold_bit(stopv, os, 1'b0);
        rx_line = 1'b1;
    endtask

    task automatic pop_one();
        @(negedge clk) rd_pop = 1'b1;
        @(negedge clk) rd_pop = 1'b0;
    endtask

    task automatic head_is(input string tag, input logic [7:0] d, input logic fe,
                           input logic pe, input logic ov);
        @(negedge clk);
        chk({tag, " avail"}, 16'(stat_rx_avail), 16'd1);
        chk({tag, " data"},  16'(rd_data), 16'(d));
        chk({tag, " fe"},    16'(stat_frm_err), 16'(fe));
        chk({tag, " pe"},    16'(stat_par_err), 16'(pe));
        chk({tag, " ovr"},   16'(stat_ovr), 16'(ov));
    endtask

    task automatic empty_is(input string tag);
        @(negedge clk);
        chk({tag, " avail"}, 16'(stat_rx_avail), 16'd0);
        chk({tag, " flags"}, 16'({stat_frm_err, stat_par_err, stat_ovr}), 16'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin : main
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        empty_is("R1 reset");

        // table walk: R2 R4 R5 R9 R10
        for (int v = 0; v < 9; v++) begin
            logic [16:0] e;
            e = VEC[v];
            send_frame(e[16:8], e[7], e[6], e[5], e[4], e[3], -1);
            wait_ticks(20);
            if (e[2]) begin
                head_is($sformatf("R2 R4 R5 R10 vec%0d", v), e[15:8], e[1], e[0], 1'b0);
                pop_one();
                empty_is($sformatf("R6 R1 after pop vec%0d", v));
            end else begin
                empty_is($sformatf("R9 dropped vec%0d", v));
            end
        end
        cfg_mp_mode = 1'b0;
        cfg_par_en  = 1'b0;
        cfg_dbl_spd = 1'b0;

        // R7: third character waits, enters on read
        send_frame(9'h011, 0, 0, 0, 1, 0, -1);
        send_frame(9'h022, 0, 0, 0, 1, 0, -1);
        send_frame(9'h033, 0, 0, 0, 1, 0, -1);
        wait_ticks(20);
        head_is("R6 order first", 8'h11, 0, 0, 0);
        pop_one();
        head_is("R7 second", 8'h22, 0, 0, 0);
        pop_one();
        head_is("R7 held moved", 8'h33, 0, 0, 0);
        pop_one();
        empty_is("R6 drained");

        // R8: fourth frame starts with buffer full and one held
        send_frame(9'h044, 0, 0, 0, 1, 0, -1);
        send_frame(9'h055, 0, 0, 0, 1, 0, -1);
        send_frame(9'h066, 0, 0, 0, 1, 0, -1);
        send_frame(9'h077, 0, 0, 0, 0, 0, -1);
        wait_ticks(20);
        head_is("R8 first clean", 8'h44, 0, 0, 0);
        pop_one();
        head_is("R8 second clean", 8'h55, 0, 0, 0);
        pop_one();
        head_is("R8 overrun tagged", 8'h77, 1, 0, 1);
        pop_one();
        empty_is("R8 drained");
        send_frame(9'h088, 0, 0, 0, 1, 0, -1);
        wait_ticks(20);
        head_is("R8 flag cleared", 8'h88, 0, 0, 0);
        pop_one();

        // R11: disabled receiver ignores the line
        cfg_rx_en = 1'b0;
        send_frame(9'h099, 0, 0, 0, 1, 0, -1);
        wait_ticks(20);
        empty_is("R11 disabled");
        cfg_rx_en = 1'b1;

        // R3: one-tick glitch at mid-cell of data bit 3 and of the start bit
        send_frame(9'h008, 0, 0, 0, 1, 0, 4);
        wait_ticks(20);
        head_is("R3 data glitch", 8'h08, 0, 0, 0);
        pop_one();
        send_frame(9'h0F7, 0, 0, 1, 1, 0, 0);
        wait_ticks(20);
        head_is("R3 R10 start glitch", 8'hF7, 0, 0, 0);
        pop_one();

        // R3: short false start
        rx_line = 1'b0;
        wait_ticks(2);
        rx_line = 1'b1;
        wait_ticks(40);
        empty_is("R3 false start");
        send_frame(9'h0C9, 0, 0, 0, 1, 0, -1);
        wait_ticks(20);
        head_is("R3 recovered", 8'hC9, 0, 0, 0);
        pop_one();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule